// File: doc/BRIEF.md
# Ethernet Transmit Error Abort Controller

This block moves one Ethernet frame at a time from a byte-wide transmit FIFO to a byte-wide MAC output. It computes the frame check sequence itself and appends it after the last payload byte. Preamble generation is handled elsewhere. A byte-time counter that starts at the preamble length stands in for the preamble, so the slot-time rule is measured from the first preamble bit.

Three error cases are handled:

- **Loss of carrier.** A start request made while the effective link is down is refused and counted.
- **Late collision.** A collision seen in half-duplex mode after one slot time makes the block stop reading payload. It then sends the bitwise complement of the correct FCS, so every receiver discards the frame, and abandons the frame.
- **FIFO underflow.** The FIFO running dry mid-frame ends the frame with the same poisoned FCS. The frame is then either flushed or, when retry is enabled, replayed from its first byte once the whole frame is resident.

Each error class has its own saturating counter with a synchronous clear.

Top module: `txErrAbort`

## Requirements
- R1: After a start with the link up, each FIFO byte read (fifoRd high in cycle t) appears on txData with txValid in cycle t+1, in FIFO order. After the byte flagged fifoLast, four FCS bytes follow on consecutive cycles. The FCS is the complement of a reflected CRC-32 (polynomial 0xEDB88320, initial value 0xFFFFFFFF) over the payload, sent least significant byte first. frameDone pulses for one cycle together with the last FCS byte on txData.
- R2: A start request while linkUp=0 and forceLink=0 reads nothing and sends nothing. It increments cntLoss by one and pulses frameAbandon and fifoFlush in the following cycle.
- R3: With forceLink=1 the link counts as up whatever linkUp is, so a start sends the frame normally.
- R4: A late collision stops payload reading, increments cntLate, and sends four FCS bytes each XORed with 0xFF, computed over the bytes sent so far. A late collision is collision=1 while fullDuplex=0, once the byte time (8 preamble bytes plus the bytes already sent in this attempt) is at least 64. frameAbandon and fifoFlush pulse together with the last of those bytes.
- R5: A collision is ignored when fullDuplex=1, when the byte time is below 64, and while the block is idle or waiting for a replay.
- R6: fifoEmpty=1 in a payload cycle is an underflow. It increments cntUnder and ends the frame with four FCS bytes XORed with 0xFF, computed over the bytes sent so far. This happens in either duplex mode.
- R7: After an underflow with retryOnUnderrun=0 (sampled at the underflow), frameAbandon and fifoFlush pulse with the last poisoned FCS byte and the frame is not resent.
- R8: After an underflow with retryOnUnderrun=1, neither fifoFlush nor frameAbandon is raised. The block waits for frameLoaded, pulses fifoRewind for one cycle, and from the next cycle resends the frame from its first byte with a fresh FCS.
- R9: Each error event raises exactly one counter by one. A late collision in the same cycle as fifoEmpty counts only as a late collision. A late collision during the FCS of a good frame poisons that byte and the remaining FCS bytes, and the frame is abandoned.
- R10: Each counter is CNT_W bits wide and holds at all ones instead of wrapping. cntClr=1 clears all three counters in the next cycle and wins over a simultaneous increment.
- R11: txStart is ignored while a frame is in progress or waiting for a replay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntClr | input | 1 | Synchronous clear of all error counters |
| txStart | input | 1 | Request to transmit the frame at the FIFO head |
| fullDuplex | input | 1 | 1 = full duplex, 0 = half duplex |
| linkUp | input | 1 | Link status from the PHY side |
| forceLink | input | 1 | Treat the link as up |
| retryOnUnderrun | input | 1 | Replay a frame that underflowed |
| collision | input | 1 | Collision seen on the medium |
| fifoData | input | 8 | Byte at the FIFO read pointer |
| fifoEmpty | input | 1 | No byte available at the read pointer |
| fifoLast | input | 1 | The byte at the read pointer ends the frame |
| frameLoaded | input | 1 | The whole frame is resident in the FIFO |
| fifoRd | output | 1 | Advance the FIFO read pointer |
| fifoRewind | output | 1 | Return the read pointer to the frame start |
| fifoFlush | output | 1 | Discard the current frame in the FIFO |
| txData | output | 8 | Byte to the MAC |
| txValid | output | 1 | txData carries a byte |
| frameDone | output | 1 | Frame sent with a good FCS |
| frameAbandon | output | 1 | Frame given up; the next may be processed |
| cntLoss | output | CNT_W | Loss-of-carrier count |
| cntLate | output | CNT_W | Late-collision count |
| cntUnder | output | CNT_W | Underflow count |

## Verification
The frame path is driven with several patterns, and each one separates a different fault:

- **Known nine-byte ASCII payload.** Pins the CRC polynomial, the initial value and the byte order of the FCS.
- **Long frames with collisions at byte times 18, 68 and in the FCS, in both duplex modes.** Separate the slot-time threshold from the duplex gate.
- **A payload that runs dry under each setting of the retry control.** Distinguishes flush-and-abandon from rewind-and-replay, and checks that a replay restarts the FCS from scratch.
- **A collision landing exactly when the FIFO empties.** Tells apart the counter priority.
- **A storm of refused starts followed by a clear.** Exposes wrap-around versus saturation and whether clear beats increment.

// File: rtl/txaPkg.sv
package txaPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_FCS,
    ST_WAIT
  } txaState_e;

  // strobes from the control to the datapath, one per cycle
  typedef struct packed {
    logic frameInit;
    logic sendData;
    logic sendFcs;
    logic invertFcs;
    logic incLoss;
    logic incLate;
    logic incUnder;
  } txaStrobe_t;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  // one byte of a reflected CRC-32, bit 0 of the byte first
  function automatic logic [31:0] crcByte(input logic [31:0] crcIn, input logic [7:0] dIn);
    logic [31:0] r;
    r = crcIn;
    for (int i = 0; i < 8; i++) begin
      r = (r >> 1) ^ (CRC_POLY & {32{r[0] ^ dIn[i]}});
    end
    return r;
  endfunction

endpackage

// File: rtl/txaDatapath.sv
module txaDatapath
  import txaPkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int PRE_BYTES  = 8,
  parameter int SLOT_BYTES = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntClr,
  input  txaStrobe_t       strobe,
  input  logic [7:0]       fifoData,
  output logic             slotLate,
  output logic             fcsLast,
  output logic [7:0]       txData,
  output logic             txValid,
  output logic [CNT_W-1:0] cntLoss,
  output logic [CNT_W-1:0] cntLate,
  output logic [CNT_W-1:0] cntUnder
);

  localparam int TIME_W = $clog2(SLOT_BYTES + 1);
  localparam logic [TIME_W-1:0] TIME_START = TIME_W'(PRE_BYTES);
  localparam logic [TIME_W-1:0] TIME_SLOT  = TIME_W'(SLOT_BYTES);
  localparam int NUM_CNT = 3;

  logic [TIME_W-1:0] timeCnt;
  logic [31:0]       crcReg;
  logic [1:0]        fcsIdx;
  logic [7:0]        fcsByte;

  // byte-time counter from the first preamble byte, held once past the slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeCnt <= '0;
    end else if (strobe.frameInit) begin
      timeCnt <= TIME_START;
    end else if ((strobe.sendData || strobe.sendFcs) && (timeCnt < TIME_SLOT)) begin
      timeCnt <= timeCnt + 1'b1;
    end
  end

  assign slotLate = (timeCnt >= TIME_SLOT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg <= '1;
    end else if (strobe.frameInit) begin
      crcReg <= '1;
    end else if (strobe.sendData) begin
      crcReg <= crcByte(crcReg, fifoData);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fcsIdx <= '0;
    end else if (strobe.frameInit) begin
      fcsIdx <= '0;
    end else if (strobe.sendFcs) begin
      fcsIdx <= fcsIdx + 1'b1;
    end
  end

  assign fcsLast = (fcsIdx == 2'd3);
  // the correct FCS is the complement of the register; poisoning flips it back
  assign fcsByte = ~crcReg[{fcsIdx, 3'b000} +: 8] ^ {8{strobe.invertFcs}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txValid <= 1'b0;
      txData  <= '0;
    end else begin
      txValid <= strobe.sendData || strobe.sendFcs;
      if (strobe.sendData) begin
        txData <= fifoData;
      end else if (strobe.sendFcs) begin
        txData <= fcsByte;
      end
    end
  end

  logic [NUM_CNT-1:0] incVec;
  logic [CNT_W-1:0]   cntArr [NUM_CNT];

  assign incVec = {strobe.incUnder, strobe.incLate, strobe.incLoss};

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntArr[g] <= '0;
      end else if (cntClr) begin
        cntArr[g] <= '0;
      end else if (incVec[g] && (cntArr[g] != {CNT_W{1'b1}})) begin
        cntArr[g] <= cntArr[g] + 1'b1;
      end
    end
  end

  assign cntLoss  = cntArr[0];
  assign cntLate  = cntArr[1];
  assign cntUnder = cntArr[2];

endmodule

// File: rtl/txaControl.sv
module txaControl
  import txaPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txStart,
  input  logic       fullDuplex,
  input  logic       linkUp,
  input  logic       forceLink,
  input  logic       retryOnUnderrun,
  input  logic       collision,
  input  logic       fifoEmpty,
  input  logic       fifoLast,
  input  logic       frameLoaded,
  input  logic       slotLate,
  input  logic       fcsLast,
  output txaStrobe_t strobe,
  output logic       fifoRd,
  output logic       fifoRewind,
  output logic       fifoFlush,
  output logic       frameDone,
  output logic       frameAbandon
);

  txaState_e state, nState;
  logic aborting, nAbort;
  logic whyUnder, nWhyUnder;
  logic retryHeld, nRetry;
  logic doneQ, doneNext;
  logic abandonQ, abandonNext;
  logic lateHit, linkOk;

  assign lateHit = collision && !fullDuplex && slotLate;
  assign linkOk  = linkUp || forceLink;

  always_comb begin
    nState      = state;
    nAbort      = aborting;
    nWhyUnder   = whyUnder;
    nRetry      = retryHeld;
    strobe      = '0;
    fifoRd      = 1'b0;
    fifoRewind  = 1'b0;
    doneNext    = 1'b0;
    abandonNext = 1'b0;
    case (state)
      ST_IDLE: begin
        if (txStart) begin
          if (linkOk) begin
            strobe.frameInit = 1'b1;
            nAbort           = 1'b0;
            nState           = ST_DATA;
          end else begin
            strobe.incLoss = 1'b1;
            abandonNext    = 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (lateHit) begin
          strobe.incLate = 1'b1;
          nAbort         = 1'b1;
          nWhyUnder      = 1'b0;
          nState         = ST_FCS;
        end else if (fifoEmpty) begin
          strobe.incUnder = 1'b1;
          nAbort          = 1'b1;
          nWhyUnder       = 1'b1;
          nRetry          = retryOnUnderrun;
          nState          = ST_FCS;
        end else begin
          strobe.sendData = 1'b1;
          fifoRd          = 1'b1;
          if (fifoLast) begin
            nState = ST_FCS;
          end
        end
      end
      ST_FCS: begin
        strobe.sendFcs = 1'b1;
        if (lateHit && !aborting) begin
          strobe.incLate = 1'b1;
          nAbort         = 1'b1;
          nWhyUnder      = 1'b0;
        end
        strobe.invertFcs = nAbort;
        if (fcsLast) begin
          if (!nAbort) begin
            doneNext = 1'b1;
            nState   = ST_IDLE;
          end else if (nWhyUnder && nRetry) begin
            nState = ST_WAIT;
          end else begin
            abandonNext = 1'b1;
            nState      = ST_IDLE;
          end
        end
      end
      ST_WAIT: begin
        if (frameLoaded) begin
          fifoRewind       = 1'b1;
          strobe.frameInit = 1'b1;
          nAbort           = 1'b0;
          nState           = ST_DATA;
        end
      end
      default: nState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      aborting  <= 1'b0;
      whyUnder  <= 1'b0;
      retryHeld <= 1'b0;
      doneQ     <= 1'b0;
      abandonQ  <= 1'b0;
    end else begin
      state     <= nState;
      aborting  <= nAbort;
      whyUnder  <= nWhyUnder;
      retryHeld <= nRetry;
      doneQ     <= doneNext;
      abandonQ  <= abandonNext;
    end
  end

  assign frameDone    = doneQ;
  assign frameAbandon = abandonQ;
  assign fifoFlush    = abandonQ;

endmodule

// File: rtl/txErrAbort.sv
module txErrAbort
  import txaPkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int PRE_BYTES  = 8,
  parameter int SLOT_BYTES = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntClr,
  input  logic             txStart,
  input  logic             fullDuplex,
  input  logic             linkUp,
  input  logic             forceLink,
  input  logic             retryOnUnderrun,
  input  logic             collision,
  input  logic [7:0]       fifoData,
  input  logic             fifoEmpty,
  input  logic             fifoLast,
  input  logic             frameLoaded,
  output logic             fifoRd,
  output logic             fifoRewind,
  output logic             fifoFlush,
  output logic [7:0]       txData,
  output logic             txValid,
  output logic             frameDone,
  output logic             frameAbandon,
  output logic [CNT_W-1:0] cntLoss,
  output logic [CNT_W-1:0] cntLate,
  output logic [CNT_W-1:0] cntUnder
);

  txaStrobe_t strobe;
  logic       slotLate;
  logic       fcsLast;

  txaControl u_ctl (
    .clk            (clk),
    .rstN           (rstN),
    .txStart        (txStart),
    .fullDuplex     (fullDuplex),
    .linkUp         (linkUp),
    .forceLink      (forceLink),
    .retryOnUnderrun(retryOnUnderrun),
    .collision      (collision),
    .fifoEmpty      (fifoEmpty),
    .fifoLast       (fifoLast),
    .frameLoaded    (frameLoaded),
    .slotLate       (slotLate),
    .fcsLast        (fcsLast),
    .strobe         (strobe),
    .fifoRd         (fifoRd),
    .fifoRewind     (fifoRewind),
    .fifoFlush      (fifoFlush),
    .frameDone      (frameDone),
    .frameAbandon   (frameAbandon)
  );

  txaDatapath #(
    .CNT_W     (CNT_W),
    .PRE_BYTES (PRE_BYTES),
    .SLOT_BYTES(SLOT_BYTES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cntClr  (cntClr),
    .strobe  (strobe),
    .fifoData(fifoData),
    .slotLate(slotLate),
    .fcsLast (fcsLast),
    .txData  (txData),
    .txValid (txValid),
    .cntLoss (cntLoss),
    .cntLate (cntLate),
    .cntUnder(cntUnder)
  );

endmodule

// File: rtl/txErrAbortChk.sv
module txErrAbortChk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cntClr,
  input logic             fullDuplex,
  input logic             fifoRd,
  input logic             txValid,
  input logic             frameDone,
  input logic             frameAbandon,
  input logic [CNT_W-1:0] cntLoss,
  input logic [CNT_W-1:0] cntLate,
  input logic [CNT_W-1:0] cntUnder
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  p_read_to_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    fifoRd |=> txValid);

  p_done_vs_abandon_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(frameDone && frameAbandon));

  p_full_duplex_no_late_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fullDuplex && !cntClr) |=> (cntLate == $past(cntLate)));

  p_one_counter_r9: assert property (@(posedge clk) disable iff (!rstN)
    !cntClr |=> ($countones({cntLoss != $past(cntLoss), cntLate != $past(cntLate),
                             cntUnder != $past(cntUnder)}) <= 1));

  p_saturate_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cntLoss == CNT_MAX && !cntClr) |=> (cntLoss == CNT_MAX));

  p_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    cntClr |=> (cntLoss == '0 && cntLate == '0 && cntUnder == '0));

endmodule

bind txErrAbort txErrAbortChk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cntClr      (cntClr),
  .fullDuplex  (fullDuplex),
  .fifoRd      (fifoRd),
  .txValid     (txValid),
  .frameDone   (frameDone),
  .frameAbandon(frameAbandon),
  .cntLoss     (cntLoss),
  .cntLate     (cntLate),
  .cntUnder    (cntUnder)
);

// File: tb/test_txErrAbort.sv
`timescale 1ns/100ps
module test_txErrAbort;

  localparam int CW   = 4;
  localparam int PRE  = 8;
  localparam int SLOT = 64;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cntClr = 0, txStart = 0, fullDuplex = 1, linkUp = 1, forceLink = 0;
  logic retryOnUnderrun = 0, collision = 0, fifoEmpty = 1, fifoLast = 0, frameLoaded = 0;
  logic [7:0] fifoData = '0;
  logic fifoRd, fifoRewind, fifoFlush, txValid, frameDone, frameAbandon;
  logic [7:0] txData;
  logic [CW-1:0] cntLoss, cntLate, cntUnder;

  always #2.5 clk = ~clk;

  txErrAbort #(.CNT_W(CW), .PRE_BYTES(PRE), .SLOT_BYTES(SLOT)) i_txErrAbort (
    .clk(clk), .rstN(rstN), .cntClr(cntClr), .txStart(txStart), .fullDuplex(fullDuplex),
    .linkUp(linkUp), .forceLink(forceLink), .retryOnUnderrun(retryOnUnderrun),
    .collision(collision), .fifoData(fifoData), .fifoEmpty(fifoEmpty), .fifoLast(fifoLast),
    .frameLoaded(frameLoaded), .fifoRd(fifoRd), .fifoRewind(fifoRewind), .fifoFlush(fifoFlush),
    .txData(txData), .txValid(txValid), .frameDone(frameDone), .frameAbandon(frameAbandon),
    .cntLoss(cntLoss), .cntLate(cntLate), .cntUnder(cntUnder));

  int vecs = 0, miss = 0, cyc = 0;
  // bench FIFO
  int frm[$]; int avail = 0, rp = 0, loadAt = -1, collAt = -1;
  int outQ[$]; int doneSeen = 0, abandonSeen = 0;
  // reference model state: 0 idle, 1 payload, 2 fcs, 3 wait
  int mSt = 0, mTime = 0, mIdx = 0, mTxD = 0;
  bit mAbort = 0, mWhyU = 0, mRetry = 0, mTxV = 0, mDone = 0, mAbn = 0;
  int mcL = 0, mcC = 0, mcU = 0;
  int sent[$];
  bit chkOn = 0;

  function automatic int unsigned refCrc(int q[$]);
    int unsigned c = 32'hFFFFFFFF;
    foreach (q[i]) begin
      for (int b = 0; b < 8; b++) begin
        if (((c ^ (q[i] >> b)) & 1) != 0) c = (c >> 1) ^ 32'hEDB88320;
        else c = c >> 1;
      end
    end
    return c;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic cmp(int act, int exp, string req);
    check(act == exp, req, act, exp);
  endtask

  function automatic int satInc(int v, bit inc);
    return (inc && v < CMAX) ? v + 1 : v;
  endfunction

  task automatic tick();
    bit late, eRd, eRew, nTxV, nDone, nAbn, nAbort, nWhy, nRet, iL, iC, iU, flushNow, rstSent;
    int nSt, nTime, nIdx, nTxD, b;
    int unsigned f;
    if (loadAt >= 0 && cyc >= loadAt) avail = frm.size();
    collision   = ((mSt == 1) || (mSt == 2)) && ((mTime - PRE) == collAt);
    fifoEmpty   = (rp >= avail);
    fifoData    = (rp < avail) ? 8'(frm[rp]) : 8'h00;
    fifoLast    = (rp < avail) && (rp == frm.size() - 1);
    frameLoaded = (frm.size() > 0) && (avail == frm.size());
    #1;
    late = collision && !fullDuplex && (mTime >= SLOT);
    eRd = 0; eRew = 0; nTxV = 0; nTxD = mTxD; nDone = 0; nAbn = 0;
    iL = 0; iC = 0; iU = 0; rstSent = 0;
    nSt = mSt; nTime = mTime; nIdx = mIdx; nAbort = mAbort; nWhy = mWhyU; nRet = mRetry;
    case (mSt)
      0: if (txStart) begin
           if (linkUp || forceLink) begin
             nSt = 1; nTime = PRE; nIdx = 0; nAbort = 0; rstSent = 1;
           end else begin
             iL = 1; nAbn = 1;
           end
         end
      1: if (late) begin
           iC = 1; nAbort = 1; nWhy = 0; nSt = 2;
         end else if (fifoEmpty) begin
           iU = 1; nAbort = 1; nWhy = 1; nRet = retryOnUnderrun; nSt = 2;
         end else begin
           eRd = 1; nTxV = 1; nTxD = fifoData; nTime = mTime + 1;
           if (fifoLast) nSt = 2;
         end
      2: begin
           if (late && !mAbort) begin iC = 1; nAbort = 1; nWhy = 0; end
           f = ~refCrc(sent);
           b = int'((f >> (8 * mIdx)) & 32'hFF);
           if (nAbort) b = b ^ 255;
           nTxV = 1; nTxD = b; nTime = mTime + 1; nIdx = mIdx + 1;
           if (mIdx == 3) begin
             if (!nAbort) begin nDone = 1; nSt = 0; end
             else if (nWhy && nRet) nSt = 3;
             else begin nAbn = 1; nSt = 0; end
           end
         end
      default: if (frameLoaded) begin
           eRew = 1; nSt = 1; nTime = PRE; nIdx = 0; nAbort = 0; rstSent = 1;
         end
    endcase
    if (chkOn) begin
      cmp(txValid, mTxV, "R1 txValid");
      if (mTxV) cmp(txData, mTxD, "R1 txData");
      cmp(fifoRd, eRd, "R1 fifoRd");
      cmp(frameDone, mDone, "R1 frameDone");
      cmp(frameAbandon, mAbn, "R7 frameAbandon");
      cmp(fifoFlush, mAbn, "R7 fifoFlush");
      cmp(fifoRewind, eRew, "R8 fifoRewind");
      cmp(cntLoss, mcL, "R2 cntLoss");
      cmp(cntLate, mcC, "R4 cntLate");
      cmp(cntUnder, mcU, "R6 cntUnder");
    end
    if (txValid) outQ.push_back(int'(txData));
    if (frameDone) doneSeen++;
    if (frameAbandon) abandonSeen++;
    flushNow = mAbn;
    if (rstSent) sent.delete();
    if (eRd) sent.push_back(int'(fifoData));
    mSt = nSt; mTime = nTime; mIdx = nIdx; mAbort = nAbort; mWhyU = nWhy; mRetry = nRet;
    mTxV = nTxV; mTxD = nTxD; mDone = nDone; mAbn = nAbn;
    if (cntClr) begin
      mcL = 0; mcC = 0; mcU = 0;
    end else begin
      mcL = satInc(mcL, iL); mcC = satInc(mcC, iC); mcU = satInc(mcU, iU);
    end
    if (eRew) rp = 0;
    if (eRd) rp++;
    if (flushNow) begin frm.delete(); avail = 0; rp = 0; end
    @(negedge clk);
    cyc++;
  endtask

  task automatic runFrame(int n, int seed, int av, int ldAt, int cAt, bit fdx, bit rty, int againAt);
    frm.delete();
    for (int i = 0; i < n; i++) frm.push_back(seed < 0 ? 8'h31 + i : (seed + i * 7) & 255);
    avail = av; rp = 0; loadAt = (ldAt < 0) ? -1 : cyc + ldAt; collAt = cAt;
    fullDuplex = fdx; retryOnUnderrun = rty; outQ.delete();
    txStart = 1; tick(); txStart = 0;
    for (int k = 0; k < 600 && mSt != 0; k++) begin
      txStart = (k == againAt); tick();
    end
    txStart = 0; tick(); tick();
    frm.delete(); avail = 0; rp = 0; collAt = -1; loadAt = -1;
  endtask

  initial begin : watchdog
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        miss++; vecs++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
      end
    end
  end

  initial begin : main
    int d0, a0, c0;
    int unsigned cr;
    @(negedge clk);
    repeat (3) @(negedge clk);
    rstN = 1;
    // reset state (R1, R10)
    #1;
    cmp(txValid, 0, "R1 reset txValid");
    cmp(cntLoss + cntLate + cntUnder, 0, "R10 reset counters");
    @(negedge clk);
    chkOn = 1;

    // R1: known payload and FCS byte order
    runFrame(9, -1, 9, -1, -1, 1, 0, -1);
    cmp(outQ.size(), 13, "R1 byte count");
    if (outQ.size() == 13) begin
      cmp(outQ[9], 8'h26, "R1 fcs byte0");
      cmp(outQ[10], 8'h39, "R1 fcs byte1");
      cmp(outQ[11], 8'hF4, "R1 fcs byte2");
      cmp(outQ[12], 8'hCB, "R1 fcs byte3");
    end
    cmp(doneSeen, 1, "R1 frameDone once");

    // R11: a second start mid-frame is ignored
    d0 = doneSeen;
    runFrame(20, 5, 20, -1, -1, 1, 0, 6);
    cmp(doneSeen - d0, 1, "R11 one frame only");
    cmp(outQ.size(), 24, "R11 no restart");

    // R2: loss of carrier
    linkUp = 0; a0 = abandonSeen;
    runFrame(10, 9, 10, -1, -1, 1, 0, -1);
    cmp(cntLoss, 1, "R2 loss count");
    cmp(abandonSeen - a0, 1, "R2 abandon");
    cmp(outQ.size(), 0, "R2 nothing sent");
    // R3: forced link
    forceLink = 1; d0 = doneSeen;
    runFrame(12, 3, 12, -1, -1, 1, 0, -1);
    cmp(doneSeen - d0, 1, "R3 forced link sends");
    forceLink = 0; linkUp = 1;

    // R4: late collision at byte time 68
    a0 = abandonSeen;
    runFrame(80, 11, 80, -1, 60, 0, 0, -1);
    cmp(cntLate, 1, "R4 late count");
    cmp(abandonSeen - a0, 1, "R4 abandon");
    cmp(outQ.size(), 64, "R4 stop after poison");
    if (outQ.size() == 64) begin
      cr = refCrc(outQ[0:59]);
      for (int i = 0; i < 4; i++)
        cmp(outQ[60 + i], int'((cr >> (8 * i)) & 255), "R4 inverted fcs");
    end

    // R5: early collision in half duplex and late collision in full duplex ignored
    d0 = doneSeen;
    runFrame(80, 13, 80, -1, 10, 0, 0, -1);
    runFrame(80, 17, 80, -1, 62, 1, 0, -1);
    cmp(doneSeen - d0, 2, "R5 collisions ignored");
    cmp(cntLate, 1, "R5 late unchanged");

    // R6 R7: underflow without retry
    a0 = abandonSeen;
    runFrame(40, 21, 15, -1, -1, 1, 0, -1);
    cmp(cntUnder, 1, "R6 under count");
    cmp(outQ.size(), 19, "R6 poison after 15 bytes");
    cmp(abandonSeen - a0, 1, "R7 abandon and flush");

    // R8: underflow with retry, replay from first byte
    a0 = abandonSeen; d0 = doneSeen;
    runFrame(40, 23, 15, 40, -1, 0, 1, -1);
    cmp(cntUnder, 2, "R8 under count");
    cmp(abandonSeen - a0, 0, "R8 no abandon");
    cmp(doneSeen - d0, 1, "R8 replay done");
    cmp(outQ.size(), 63, "R8 replay length");
    if (outQ.size() == 63) begin
      for (int i = 0; i < 40; i++) cmp(outQ[19 + i], (23 + i * 7) & 255, "R8 replay bytes");
      cr = ~refCrc(outQ[19:58]);
      cmp(outQ[59], int'(cr & 255), "R8 fresh fcs");
    end

    // R9: collision and empty together; collision during good FCS
    c0 = cntUnder;
    runFrame(80, 29, 60, -1, 60, 0, 0, -1);
    cmp(cntLate, 2, "R9 collision wins");
    cmp(cntUnder, c0, "R9 no under count");
    a0 = abandonSeen;
    runFrame(70, 31, 70, -1, 71, 0, 0, -1);
    cmp(cntLate, 3, "R9 fcs collision");
    cmp(abandonSeen - a0, 1, "R9 fcs collision abandon");

    // R10: saturation and clear priority
    linkUp = 0;
    for (int i = 0; i < 20; i++) begin txStart = 1; tick(); txStart = 0; tick(); end
    cmp(cntLoss, CMAX, "R10 saturate");
    txStart = 1; cntClr = 1; tick(); txStart = 0; cntClr = 0; tick();
    cmp(cntLoss + cntLate + cntUnder, 0, "R10 clear wins");
    linkUp = 1;
    repeat (3) tick();

    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

endmodule